// File: doc/BRIEF.md
# System-Call Exception Entry Unit

This block watches a stream of fetched instruction words, each presented with its fetch address and a valid flag. When a word decodes as a system-call instruction, the unit performs exception entry in a single clock edge. The prior machine-state register is preserved in one save/restore register, and the return address goes into the other. Five machine-state control bits are cleared. A redirect target is formed from the upper half of a vector-prefix register and a fixed offset of 0x0C00.

The unit owns the four architectural registers: machine state, vector prefix, save/restore 0 and save/restore 1. Each register has a write port for move-to-register instructions, and its current value is visible at an output. In the cycle after an accepted system call, a one-cycle redirect pulse and a pipeline-flush request come out together. The updated registers are visible in that same cycle, so instructions fetched from the target run under the new machine state.

Top module: `scx_entry_unit`

## Requirements
- R1: A word is recognised as a system call when `in_vld` is 1, word bits [31:26] equal 6'd17, and word bit [1] is 1 (bit 0 is the most significant bit in big-endian numbering, which makes these big-endian bits 0–5 and 30).
- R2: On a recognised call, `srr1_q` takes the value `msr_q` held before the edge, which is the value before any clearing.
- R3: On a recognised call, `srr0_q` takes `in_addr + 4`, wrapping modulo 2^32.
- R4: On a recognised call, `msr_q` becomes the old value with bits [18], [15], [14], [5] and [4] forced to 0. That is the mask 0x0004_C030, which covers the five control flags at big-endian positions 13, 16, 17, 27 and 26. All other bits are kept.
- R5: When `redir_vld` is 1, `redir_tgt` equals {`evpr_q` bits [31:16] as held before the accepting edge, 16'h0C00}.
- R6: `redir_vld` and `flush_req` are both 1 for exactly the one cycle after each accepting edge. In that same cycle the new `msr_q`, `srr0_q` and `srr1_q` are visible.
- R7: A word that is not recognised, or that has `in_vld` at 0, changes no register through the call path and gives `redir_vld` = `flush_req` = 0 in the next cycle.
- R8: With no call accepted, a write enable loads its register from its write data at the edge. When a call is accepted in the same cycle, writes to the machine-state and save/restore registers are dropped. A prefix write still loads, but the target uses the prefix value from before that write.
- R9: Nonzero values in any word bits other than [31:26] and [1] do not prevent recognition.
- R10: While `rst` is 1, every register output, `redir_vld`, `flush_req` and `redir_tgt` go to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Instruction word is valid |
| in_word | input | 32 | Fetched instruction word |
| in_addr | input | 32 | Fetch address of the word |
| msr_we | input | 1 | Machine-state write enable |
| msr_wdata | input | 32 | Machine-state write data |
| evpr_we | input | 1 | Vector-prefix write enable |
| evpr_wdata | input | 32 | Vector-prefix write data |
| srr0_we | input | 1 | Save/restore 0 write enable |
| srr0_wdata | input | 32 | Save/restore 0 write data |
| srr1_we | input | 1 | Save/restore 1 write enable |
| srr1_wdata | input | 32 | Save/restore 1 write data |
| msr_q | output | 32 | Machine-state register |
| evpr_q | output | 32 | Vector-prefix register |
| srr0_q | output | 32 | Save/restore 0 register |
| srr1_q | output | 32 | Save/restore 1 register |
| redir_vld | output | 1 | One-cycle redirect pulse |
| redir_tgt | output | 32 | Redirect target address |
| flush_req | output | 1 | Context-synchronise flush request |

## Verification
The case that matters is a software register write that lands on the same edge as an accepted system call. To provoke it, the random stimulus raises write enables on about a quarter of cycles while about a third of words are system calls. Directed steps also assert all four write enables together with a call. A reference model in the bench decides the outcome: writes to the machine-state and save/restore registers are dropped, the prefix write is taken, and the target is built from the prefix value held before that write.

// File: rtl/scx_pkg.sv
package scx_pkg;

    localparam int XW = 32;

    typedef logic [XW-1:0] word_t;

    // Result of the instruction decoder
    typedef struct packed {
        logic  hit;
        word_t ret_addr;
    } sc_dec_t;

    // Architectural state owned by the unit
    typedef struct packed {
        word_t msr;
        word_t evpr;
        word_t srr0;
        word_t srr1;
    } arch_regs_t;

    localparam logic [5:0]  SC_PRIMARY = 6'd17;
    localparam logic [15:0] SC_VEC_OFS = 16'h0C00;

    // Big-endian bit position to a single-bit mask
    function automatic word_t be_mask(input int pos);
        return word_t'(1) << (XW - 1 - pos);
    endfunction

    // Fetch address to return address
    function automatic word_t next_seq(input word_t a);
        return a + word_t'(4);
    endfunction

endpackage

// File: rtl/scx_decode.sv
module scx_decode
    import scx_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic    in_vld,
    input  word_t   in_word,
    input  word_t   in_addr,
    output sc_dec_t dec
);
    localparam int OPC_LSB = XW - OPC_W;

    logic opc_ok;
    logic form_ok;

    // Only primary opcode and the fixed form bit matter; all else is don't-care
    assign opc_ok  = (in_word[XW-1:OPC_LSB] == OPC_W'(SC_PRIMARY));
    assign form_ok = in_word[1];

    always_comb begin
        dec.hit      = in_vld && opc_ok && form_ok;
        dec.ret_addr = next_seq(in_addr);
    end

endmodule

// File: rtl/scx_msr_mask.sv
module scx_msr_mask
    import scx_pkg::*;
#(
    parameter int WE_POS = 13,
    parameter int EE_POS = 16,
    parameter int PR_POS = 17,
    parameter int DR_POS = 27,
    parameter int IR_POS = 26
) (
    input  word_t msr_in,
    output word_t msr_out
);
    localparam word_t CLR_MASK = be_mask(WE_POS) | be_mask(EE_POS) |
                                 be_mask(PR_POS) | be_mask(DR_POS) |
                                 be_mask(IR_POS);

    for (genvar i = 0; i < XW; i++) begin : g_bit
        if (CLR_MASK[i]) begin : g_clr
            assign msr_out[i] = 1'b0;
        end else begin : g_keep
            assign msr_out[i] = msr_in[i];
        end
    end

endmodule

// File: rtl/scx_vector.sv
module scx_vector
    import scx_pkg::*;
#(
    parameter logic [XW/2-1:0] OFS = SC_VEC_OFS
) (
    input  word_t evpr,
    output word_t target
);
    localparam int HW = XW / 2;

    assign target = {evpr[XW-1 -: HW], OFS};

endmodule

// File: rtl/scx_entry_unit.sv
module scx_entry_unit
    import scx_pkg::*;
#(
    parameter int WE_POS = 13,
    parameter int EE_POS = 16,
    parameter int PR_POS = 17,
    parameter int DR_POS = 27,
    parameter int IR_POS = 26
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_vld,
    input  logic [31:0] in_word,
    input  logic [31:0] in_addr,
    input  logic        msr_we,
    input  logic [31:0] msr_wdata,
    input  logic        evpr_we,
    input  logic [31:0] evpr_wdata,
    input  logic        srr0_we,
    input  logic [31:0] srr0_wdata,
    input  logic        srr1_we,
    input  logic [31:0] srr1_wdata,
    output logic [31:0] msr_q,
    output logic [31:0] evpr_q,
    output logic [31:0] srr0_q,
    output logic [31:0] srr1_q,
    output logic        redir_vld,
    output logic [31:0] redir_tgt,
    output logic        flush_req
);
    sc_dec_t    dec;
    arch_regs_t cur;
    arch_regs_t nxt;
    word_t      msr_cleared;
    word_t      vec_tgt;
    logic       sc_hit;

    scx_decode u_dec (
        .in_vld  (in_vld),
        .in_word (in_word),
        .in_addr (in_addr),
        .dec     (dec)
    );

    scx_msr_mask #(
        .WE_POS (WE_POS),
        .EE_POS (EE_POS),
        .PR_POS (PR_POS),
        .DR_POS (DR_POS),
        .IR_POS (IR_POS)
    ) u_mask (
        .msr_in  (cur.msr),
        .msr_out (msr_cleared)
    );

    scx_vector u_vec (
        .evpr   (cur.evpr),
        .target (vec_tgt)
    );

    assign sc_hit = dec.hit;

    // Next state: call entry outranks software writes except the prefix
    always_comb begin
        nxt = cur;
        if (evpr_we) nxt.evpr = evpr_wdata;
        if (sc_hit) begin
            nxt.srr1 = cur.msr;
            nxt.srr0 = dec.ret_addr;
            nxt.msr  = msr_cleared;
        end else begin
            if (msr_we)  nxt.msr  = msr_wdata;
            if (srr0_we) nxt.srr0 = srr0_wdata;
            if (srr1_we) nxt.srr1 = srr1_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            redir_vld <= 1'b0;
            flush_req <= 1'b0;
            redir_tgt <= '0;
        end else begin
            cur       <= nxt;
            redir_vld <= sc_hit;
            flush_req <= sc_hit;
            if (sc_hit) redir_tgt <= vec_tgt;
        end
    end

    assign msr_q  = cur.msr;
    assign evpr_q = cur.evpr;
    assign srr0_q = cur.srr0;
    assign srr1_q = cur.srr1;

    localparam word_t CLR_CHK = be_mask(WE_POS) | be_mask(EE_POS) |
                                be_mask(PR_POS) | be_mask(DR_POS) |
                                be_mask(IR_POS);

    AST_SAVE_MSR: assert property (@(posedge clk) disable iff (rst)
        (!rst && sc_hit) |=> (srr1_q == $past(msr_q)));                     // R2
    AST_RET_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!rst && sc_hit) |=> (srr0_q == $past(in_addr) + 32'd4));            // R3
    AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!rst && sc_hit) |=> ((msr_q & CLR_CHK) == '0 &&
                              (msr_q & ~CLR_CHK) == ($past(msr_q) & ~CLR_CHK))); // R4
    AST_VEC_TGT: assert property (@(posedge clk) disable iff (rst)
        (!rst && sc_hit) |=> (redir_tgt == {$past(evpr_q[31:16]), 16'h0C00})); // R5
    AST_PULSE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (!rst && sc_hit) |=> (redir_vld && flush_req));                      // R6
    AST_NO_REDIR: assert property (@(posedge clk) disable iff (rst)
        (!rst && !sc_hit) |=> (!redir_vld && !flush_req));                   // R7
    AST_PREFIX_WR: assert property (@(posedge clk) disable iff (rst)
        (!rst && evpr_we) |=> (evpr_q == $past(evpr_wdata)));                // R8
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!redir_vld && !flush_req && msr_q == '0 && srr0_q == '0)); // R10

endmodule

// File: tb/scx_entry_unit_test.sv
module scx_entry_unit_test;

    localparam int CLK_PER = 10;
    localparam logic [31:0] CLR = 32'h0004_C030;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [31:0] in_word, in_addr;
    logic        msr_we, evpr_we, srr0_we, srr1_we;
    logic [31:0] msr_wdata, evpr_wdata, srr0_wdata, srr1_wdata;
    logic [31:0] msr_q, evpr_q, srr0_q, srr1_q, redir_tgt;
    logic        redir_vld, flush_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state
    logic [31:0] m_msr, m_evpr, m_srr0, m_srr1;

    always #(CLK_PER/2) clk = ~clk;

    scx_entry_unit uut (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_word(in_word), .in_addr(in_addr),
        .msr_we(msr_we), .msr_wdata(msr_wdata),
        .evpr_we(evpr_we), .evpr_wdata(evpr_wdata),
        .srr0_we(srr0_we), .srr0_wdata(srr0_wdata),
        .srr1_we(srr1_we), .srr1_wdata(srr1_wdata),
        .msr_q(msr_q), .evpr_q(evpr_q), .srr0_q(srr0_q), .srr1_q(srr1_q),
        .redir_vld(redir_vld), .redir_tgt(redir_tgt), .flush_req(flush_req)
    );

    function automatic bit is_sc(input logic v, input logic [31:0] w);
        return v && (w[31:26] == 6'd17) && w[1];
    endfunction

    function automatic logic [31:0] sc_word(input logic [31:0] r);
        return {6'd17, r[25:2], 1'b1, r[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_vld = 0; in_word = 0; in_addr = 0;
        msr_we = 0; evpr_we = 0; srr0_we = 0; srr1_we = 0;
        msr_wdata = 0; evpr_wdata = 0; srr0_wdata = 0; srr1_wdata = 0;
    endtask

    // Inputs are driven at a negedge; results are read at the next negedge
    task automatic step();
        bit hit;
        logic [31:0] e_tgt;
        hit   = is_sc(in_vld, in_word);
        e_tgt = {m_evpr[31:16], 16'h0C00};
        if (hit) begin
            m_srr1 = m_msr;
            m_srr0 = in_addr + 32'd4;
            m_msr  = m_msr & ~CLR;
        end else begin
            if (msr_we)  m_msr  = msr_wdata;
            if (srr0_we) m_srr0 = srr0_wdata;
            if (srr1_we) m_srr1 = srr1_wdata;
        end
        if (evpr_we) m_evpr = evpr_wdata;
        @(negedge clk);
        if (hit) begin
            check("R2 srr1", srr1_q, m_srr1);
            check("R3 srr0", srr0_q, m_srr0);
            check("R4 msr", msr_q, m_msr);
            check("R5 target", redir_tgt, e_tgt);
            check("R6 redir_vld", {31'b0, redir_vld}, 32'd1);
            check("R6 flush_req", {31'b0, flush_req}, 32'd1);
        end else begin
            check("R7/R8 msr", msr_q, m_msr);
            check("R7/R8 srr0", srr0_q, m_srr0);
            check("R7/R8 srr1", srr1_q, m_srr1);
            check("R7 redir_vld", {31'b0, redir_vld}, 32'd0);
            check("R7 flush_req", {31'b0, flush_req}, 32'd0);
        end
        check("R8 evpr", evpr_q, m_evpr);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst = 1;
        in_vld = 1; in_word = 32'h4400_0002; // call during reset must be ignored
        @(negedge clk); @(negedge clk);
        // R10 reset state
        check("R10 msr", msr_q, 0);
        check("R10 evpr", evpr_q, 0);
        check("R10 srr0", srr0_q, 0);
        check("R10 srr1", srr1_q, 0);
        check("R10 redir_vld", {31'b0, redir_vld}, 0);
        check("R10 flush_req", {31'b0, flush_req}, 0);
        check("R10 target", redir_tgt, 0);
        rst = 0;
        m_msr = 0; m_evpr = 0; m_srr0 = 0; m_srr1 = 0;
        idle_inputs();

        // R8 preload through the write ports
        msr_we = 1; msr_wdata = 32'hFFFF_FFFF;
        evpr_we = 1; evpr_wdata = 32'hABCD_1234;
        step();
        idle_inputs();

        // R1 plain call, all bits of the mask set beforehand
        in_vld = 1; in_word = 32'h4400_0002; in_addr = 32'h0000_1000;
        step();
        check("R4 cleared bits", msr_q & CLR, 0);
        idle_inputs();
        step();
        check("R6 single pulse", {31'b0, redir_vld}, 0);

        // R9 reserved bits all ones still a call; R3 address wrap
        in_vld = 1; in_word = 32'h47FF_FFFF; in_addr = 32'hFFFF_FFFC;
        step();
        check("R3 wrap", srr0_q, 32'h0000_0000);

        // R1 form bit clear: not a call
        in_vld = 1; in_word = 32'h4400_0000; in_addr = 32'h2000;
        step();
        // R1 wrong opcode
        in_vld = 1; in_word = 32'h4000_0002;
        step();
        // R7 valid low with call encoding
        in_vld = 0; in_word = 32'h4400_0002;
        step();

        // R8 call collides with all four writes
        in_vld = 1; in_word = 32'h4400_0002; in_addr = 32'h0000_4440;
        msr_we = 1; msr_wdata = 32'h1234_5678;
        srr0_we = 1; srr0_wdata = 32'h5555_5555;
        srr1_we = 1; srr1_wdata = 32'h6666_6666;
        evpr_we = 1; evpr_wdata = 32'h7777_0000;
        step();
        check("R8 target uses old prefix", redir_tgt, 32'hABCD_0C00);
        idle_inputs();

        // Back-to-back calls
        for (int k = 0; k < 3; k++) begin
            in_vld = 1; in_word = sc_word($urandom); in_addr = $urandom;
            step();
        end
        idle_inputs();

        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = $urandom_range(0, 2);
            in_vld  = ($urandom_range(0, 7) != 0);
            in_word = (sel == 0) ? sc_word($urandom) : $urandom;
            in_addr = $urandom & 32'hFFFF_FFFC;
            msr_we  = ($urandom_range(0, 3) == 0); msr_wdata  = $urandom;
            evpr_we = ($urandom_range(0, 3) == 0); evpr_wdata = $urandom;
            srr0_we = ($urandom_range(0, 3) == 0); srr0_wdata = $urandom;
            srr1_we = ($urandom_range(0, 3) == 0); srr1_wdata = $urandom;
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule